// File: doc/BRIEF.md
# Prescaled Periodic Tick Generator

This block produces the periodic tick interrupt of a real-time-clock peripheral. It runs from a reference enable strobe that pulses at 32768 Hz in the system clock domain. A free-running binary divider on that strobe yields a slower step rate of 32768 / 2^N Hz, where N is a four-bit select field of the control register. A down-counter steps at that rate from a programmable reload value. Each time it runs out, it raises a pending flag and the tick interrupt, then reloads itself and keeps going.

Software uses a small synchronous register port with a write strobe, a two-bit address and a combinational read path. Through it software sets the control word and the reload value, reads the live count, and acknowledges pending flags by writing ones. The block also keeps a one-second divider, which starts and stops with the global enable and emits a one-cycle strobe every 32768 reference strobes for the calendar logic outside. The alarm comparison lives outside the block. Only its pending flag and its interrupt line share the status register here, and they are set by a one-cycle `alarm_hit` input.

Top module: `rtc_tick_timer`

## Requirements
- R1: After reset every register reads 0, `tick_irq`, `alarm_irq` and `sec_stb` are low, and neither counter runs.
- R2: Once started, the tick pending flag is set every reload×2^N reference strobes, where N is control bits [7:4]. The divider is free-running, so only the first interval depends on its phase.
- R3: A write to the reload register (address 1) is stored only when the full write value is greater than 2. Otherwise the register keeps its previous value.
- R4: A control write (address 0) that takes bit 8 (tick enable) from 0 to 1 while the written bit 0 (global enable) is 1 and the reload is nonzero loads the counter with the reload value and starts it. Without the global enable, or with a zero reload, the counter does not start.
- R5: A control write that takes the tick enable from 1 to 0 while keeping the global enable at 1 stops the counter, which then holds its value.
- R6: A control write that takes the global enable from 1 to 0 stops both the tick counter and the one-second divider.
- R7: When the count expires, status bit 0 is set, `tick_irq` goes high, and the counter reloads and keeps running.
- R8: Writing to the status register (address 3) clears bit 0 (tick) and bit 1 (alarm) wherever the written bit is 1, and drops the matching interrupt. Bits written as 0 have no effect.
- R9: Address 2 returns the current count, which is frozen while the counter is stopped.
- R10: A pulse on `alarm_hit` sets status bit 1 and raises `alarm_irq`.
- R11: Once the global enable rises, `sec_stb` pulses for one cycle every 32768 reference strobes.
- R12: Address 0 reads back the low 9 bits of the last control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_stb | input | 1 | 32768 Hz reference enable strobe |
| alarm_hit | input | 1 | One-cycle alarm match from the external alarm logic |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 reload, 2 count, 3 status |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` (combinational) |
| tick_irq | output | 1 | Tick interrupt, high while status bit 0 is set |
| alarm_irq | output | 1 | Alarm interrupt, high while status bit 1 is set |
| sec_stb | output | 1 | One-cycle pulse per second of reference time |

## Verification
The assertions check on every cycle the rules that tie register state together. A rejected reload write leaves the reload register unchanged. A running counter never holds zero. The counter never runs while the global enable is off. Every expiry raises the tick interrupt on the next cycle. A clearing status write drops it. The second strobe never lasts two cycles.

Only the bench scenarios can show the actual period for each prescaler setting and the freezing of the count on each kind of stop. They also show that a start without the global enable or without a reload is refused, and that the one-second interval is exact.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;
   // register addresses
   localparam logic [1:0] ADR_CTRL   = 2'd0;
   localparam logic [1:0] ADR_RELOAD = 2'd1;
   localparam logic [1:0] ADR_COUNT  = 2'd2;
   localparam logic [1:0] ADR_STATUS = 2'd3;
   // control word layout
   localparam int CTRL_W     = 9;
   localparam int BIT_GLOBAL = 0;
   localparam int SEL_LSB    = 4;
   localparam int BIT_TICK   = 8;
   // status bits
   localparam int ST_TICK    = 0;
   localparam int ST_ALARM   = 1;
   // smallest reload value that a write accepts
   localparam int RELOAD_MIN = 3;
endpackage

// File: rtl/rtc_tick_prescaler.sv
module rtc_tick_prescaler #(
   parameter int SEL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_stb,
   input  logic [SEL_W-1:0] sel,
   output logic             step_stb
);
   localparam int DIV_W = (1 << SEL_W) - 1;

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] mask;

   // mask has the low 'sel' bits set
   for (genvar i = 0; i < DIV_W; i++) begin : g_mask
      assign mask[i] = (sel > SEL_W'(i));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       div_q <= '0;
      else if (ref_stb) div_q <= div_q + 1'b1;
   end

   assign step_stb = ref_stb && ((div_q & mask) == mask);
endmodule

// File: rtl/rtc_tick_down.sv
module rtc_tick_down #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic             step,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] count,
   output logic             running,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;

   assign expire = run_q && step && !start && !stop && (cnt_q == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (start) begin
         cnt_q <= reload;
         run_q <= 1'b1;
      end else if (stop) begin
         run_q <= 1'b0;
      end else if (run_q && step) begin
         if (cnt_q == ONE) cnt_q <= reload;
         else              cnt_q <= cnt_q - ONE;
      end
   end

   assign count   = cnt_q;
   assign running = run_q;
endmodule

// File: rtl/rtc_sec_divider.sv
module rtc_sec_divider #(
   parameter int REF_HZ = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic stop,
   input  logic ref_stb,
   output logic sec_stb
);
   localparam int SW = $clog2(REF_HZ);
   localparam logic [SW-1:0] LAST = SW'(REF_HZ - 1);

   logic [SW-1:0] cnt_q;
   logic          run_q;
   logic          pulse_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         run_q   <= 1'b0;
         pulse_q <= 1'b0;
      end else if (start) begin
         cnt_q   <= '0;
         run_q   <= 1'b1;
         pulse_q <= 1'b0;
      end else if (stop) begin
         run_q   <= 1'b0;
         pulse_q <= 1'b0;
      end else if (run_q && ref_stb) begin
         pulse_q <= (cnt_q == LAST);
         cnt_q   <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end else begin
         pulse_q <= 1'b0;
      end
   end

   assign sec_stb = pulse_q;
endmodule

// File: rtl/rtc_tick_timer.sv
module rtc_tick_timer
   import rtc_tick_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16,
   parameter int SEL_W  = 4,
   parameter int REF_HZ = 32768
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_stb,
   input  logic              alarm_hit,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              tick_irq,
   output logic              alarm_irq,
   output logic              sec_stb
);
   // elaboration-time parameter checks
   if (SEL_W < 1 || SEL_W > 4 + SEL_LSB - 4 || SEL_LSB + SEL_W > BIT_TICK) begin : g_bad_sel
      $error("SEL_W must fit between the enable bits");
   end
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("CNT_W must lie in 2..DATA_W");
   end
   if (DATA_W < CTRL_W) begin : g_bad_data
      $error("DATA_W must hold the control word");
   end
   if (REF_HZ < 2) begin : g_bad_ref
      $error("REF_HZ must be at least 2");
   end

   logic [CTRL_W-1:0] ctrl_q;
   logic [CNT_W-1:0]  reload_q;
   logic [1:0]        stat_q;

   logic              wr_ctrl, wr_reload, wr_stat;
   logic              new_glb, new_tick;
   logic              tick_start, tick_stop, sec_start, sec_stop;
   logic              step_stb, tick_expire, tick_run;
   logic [CNT_W-1:0]  tick_cnt;
   logic [SEL_W-1:0]  sel;

   assign wr_ctrl   = wr_en && (addr == ADR_CTRL);
   assign wr_reload = wr_en && (addr == ADR_RELOAD);
   assign wr_stat   = wr_en && (addr == ADR_STATUS);
   assign new_glb   = wdata[BIT_GLOBAL];
   assign new_tick  = wdata[BIT_TICK];
   assign sel       = ctrl_q[SEL_LSB +: SEL_W];

   // edge-driven start and stop decisions
   assign tick_start = wr_ctrl && new_glb && new_tick && !ctrl_q[BIT_TICK]
                       && (reload_q != '0);
   assign tick_stop  = wr_ctrl && ((new_glb && !new_tick && ctrl_q[BIT_TICK])
                                   || (!new_glb && ctrl_q[BIT_GLOBAL]));
   assign sec_start  = wr_ctrl && new_glb && !ctrl_q[BIT_GLOBAL];
   assign sec_stop   = wr_ctrl && !new_glb && ctrl_q[BIT_GLOBAL];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         reload_q <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0];
         if (wr_reload && (wdata >= DATA_W'(RELOAD_MIN)))
            reload_q <= wdata[CNT_W-1:0];
      end
   end

   // pending flags: a new event wins over a same-cycle clear
   logic [1:0] clr_mask, set_mask;
   assign clr_mask = wr_stat ? wdata[1:0] : 2'b00;
   assign set_mask = {alarm_hit, tick_expire};

   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~clr_mask) | set_mask;
   end

   rtc_tick_prescaler #(.SEL_W(SEL_W)) i_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_stb  (ref_stb),
      .sel      (sel),
      .step_stb (step_stb)
   );

   rtc_tick_down #(.CNT_W(CNT_W)) i_down (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (tick_start),
      .stop    (tick_stop),
      .step    (step_stb),
      .reload  (reload_q),
      .count   (tick_cnt),
      .running (tick_run),
      .expire  (tick_expire)
   );

   rtc_sec_divider #(.REF_HZ(REF_HZ)) i_sec (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (sec_start),
      .stop    (sec_stop),
      .ref_stb (ref_stb),
      .sec_stb (sec_stb)
   );

   always_comb begin
      unique case (addr)
         ADR_CTRL:   rdata = DATA_W'(ctrl_q);
         ADR_RELOAD: rdata = DATA_W'(reload_q);
         ADR_COUNT:  rdata = DATA_W'(tick_cnt);
         default:    rdata = DATA_W'(stat_q);
      endcase
   end

   assign tick_irq  = stat_q[ST_TICK];
   assign alarm_irq = stat_q[ST_ALARM];
endmodule

// File: rtl/rtc_tick_checker.sv
module rtc_tick_checker #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        addr,
   input logic [DATA_W-1:0] wdata,
   input logic [CNT_W-1:0]  reload_q,
   input logic [CNT_W-1:0]  tick_cnt,
   input logic              tick_run,
   input logic              tick_expire,
   input logic              glb_en,
   input logic              tick_irq,
   input logic              sec_stb
);
   p_reject_small_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd1 && wdata < DATA_W'(3)) |=> $stable(reload_q));

   p_run_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick_run |-> (tick_cnt != '0));

   p_global_off_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |-> !tick_run);

   p_expire_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tick_expire |=> tick_irq);

   p_w1c_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd3 && wdata[0] && !tick_expire) |=> !tick_irq);

   p_sec_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sec_stb |=> !sec_stb);
endmodule

bind rtc_tick_timer rtc_tick_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .addr        (addr),
   .wdata       (wdata),
   .reload_q    (reload_q),
   .tick_cnt    (tick_cnt),
   .tick_run    (tick_run),
   .tick_expire (tick_expire),
   .glb_en      (ctrl_q[0]),
   .tick_irq    (tick_irq),
   .sec_stb     (sec_stb)
);

// File: tb/test_rtc_tick_timer.sv
module test_rtc_tick_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_stb = 1'b0;
   logic        alarm_hit = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        tick_irq, alarm_irq, sec_stb;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rtc_tick_timer i_rtc_tick_timer (
      .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .alarm_hit(alarm_hit),
      .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
      .tick_irq(tick_irq), .alarm_irq(alarm_irq), .sec_stb(sec_stb)
   );

   typedef struct packed {
      logic [3:0]  sel;
      logic [15:0] rel;
      logic [31:0] per;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{sel: 4'd0, rel: 16'd3,  per: 32'd3},
      '{sel: 4'd0, rel: 16'd10, per: 32'd10},
      '{sel: 4'd1, rel: 16'd5,  per: 32'd10},
      '{sel: 4'd2, rel: 16'd7,  per: 32'd28},
      '{sel: 4'd4, rel: 16'd4,  per: 32'd64},
      '{sel: 4'd6, rel: 16'd3,  per: 32'd192}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0; ref_stb = 1'b0; alarm_hit = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic pulse_ref(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ref_stb = 1'b1;
         @(negedge clk); ref_stb = 1'b0;
      end
   endtask

   task automatic wait_tick(input int limit, output int at);
      at = -1;
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         if (tick_irq) begin at = cyc; break; end
      end
   endtask

   // watchdog
   initial begin
      #(8 * 190000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int t0, t1, hit;

      // R1: reset state
      do_reset();
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         chk("R1 register reset value", v, 32'h0);
      end
      chk("R1 tick_irq low", 32'(tick_irq), 0);
      chk("R1 alarm_irq low", 32'(alarm_irq), 0);
      chk("R1 sec_stb low", 32'(sec_stb), 0);

      // R2 / R7: vector table of prescaler and reload settings
      foreach (VECS[k]) begin
         do_reset();
         ref_stb = 1'b1;
         wr(2'd1, 32'(VECS[k].rel));
         wr(2'd0, 32'h101 | (32'(VECS[k].sel) << 4));
         wait_tick(1000, t0);
         chk("R7 first expiry raises tick_irq", 32'(t0 >= 0), 1);
         wr(2'd3, 32'h1);
         wait_tick(1000, t1);
         chk("R2 tick period", 32'(t1 - t0), VECS[k].per);
         chk("R7 counter reloads and keeps running", 32'(t1 >= 0), 1);
      end

      // R3: small reload values are rejected
      do_reset();
      wr(2'd1, 32'd40);
      wr(2'd1, 32'd2);
      rd(2'd1, v); chk("R3 write of 2 ignored", v, 32'd40);
      wr(2'd1, 32'd0);
      rd(2'd1, v); chk("R3 write of 0 ignored", v, 32'd40);
      wr(2'd1, 32'd3);
      rd(2'd1, v); chk("R3 write of 3 accepted", v, 32'd3);

      // R4: no start with a zero reload
      do_reset();
      ref_stb = 1'b1;
      wr(2'd0, 32'h101);
      repeat (30) @(negedge clk);
      chk("R4 zero reload does not start", 32'(tick_irq), 0);

      // R4: no start without the global enable
      do_reset();
      ref_stb = 1'b1;
      wr(2'd1, 32'd5);
      wr(2'd0, 32'h100);
      repeat (30) @(negedge clk);
      chk("R4 no start without global enable", 32'(tick_irq), 0);
      rd(2'd2, v); chk("R4 count not loaded", v, 32'd0);
      ref_stb = 1'b0;

      // R12: control readback
      wr(2'd0, 32'hFFFF_F151);
      rd(2'd0, v); chk("R12 control readback", v, 32'h151);

      // R9 / R5 / R6: count readback and freezing
      do_reset();
      wr(2'd1, 32'd50);
      wr(2'd0, 32'h101);
      rd(2'd2, v); chk("R9 count loaded with reload", v, 32'd50);
      pulse_ref(5);
      rd(2'd2, v); chk("R9 count after five steps", v, 32'd45);
      wr(2'd0, 32'h000);
      pulse_ref(5);
      rd(2'd2, v); chk("R6 global off freezes count", v, 32'd45);
      wr(2'd0, 32'h101);
      pulse_ref(3);
      rd(2'd2, v); chk("R4 restart reloads", v, 32'd47);
      wr(2'd0, 32'h001);
      pulse_ref(4);
      rd(2'd2, v); chk("R5 tick off freezes count", v, 32'd47);

      // R10 / R8: alarm pending and write-one-to-clear
      do_reset();
      @(negedge clk); alarm_hit = 1'b1;
      @(negedge clk); alarm_hit = 1'b0;
      chk("R10 alarm_irq raised", 32'(alarm_irq), 1);
      rd(2'd3, v); chk("R10 status bit 1 set", v, 32'h2);
      wr(2'd3, 32'h0);
      chk("R8 writing 0 leaves alarm set", 32'(alarm_irq), 1);
      wr(2'd3, 32'h1);
      chk("R8 writing bit 0 leaves alarm set", 32'(alarm_irq), 1);
      wr(2'd3, 32'h2);
      chk("R8 writing bit 1 clears alarm", 32'(alarm_irq), 0);

      // R11 / R6: one-second strobe
      do_reset();
      ref_stb = 1'b1;
      wr(2'd0, 32'h001);
      t0 = cyc;
      hit = -1;
      for (int i = 0; i < 33000; i++) begin
         @(negedge clk);
         if (sec_stb) begin hit = cyc; break; end
      end
      chk("R11 first second strobe interval", 32'(hit - t0), 32'd32768);
      @(negedge clk);
      chk("R11 strobe lasts one cycle", 32'(sec_stb), 0);
      wr(2'd0, 32'h000);
      hit = 0;
      for (int i = 0; i < 33000; i++) begin
         @(negedge clk);
         if (sec_stb) hit = 1;
      end
      chk("R6 global off stops second strobe", 32'(hit), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule